// File: doc/BRIEF.md
# Edge, Level and Pin-Change Interrupt Controller

The block turns activity on input pins into interrupt requests. Two dedicated request inputs, called source A and source B, each have a two-bit sense mode: low level, any change, falling edge or rising edge. Twenty-four general pins are watched for toggles in three groups. Each group has its own mask register, and a group raises one shared request when any of its unmasked pins changes in either direction. The block only looks at pin values. A pin that the chip itself drives as an output therefore still raises requests, and software can use that to trigger an interrupt by writing the pin.

All pins pass through a two-flop synchronizer. A previous-value register per pin then feeds the clocked edge and toggle detection. Edge and toggle events set sticky flags. Software clears a flag by writing 1 to its bit. The interrupt output is the OR of every flag that has its enable bit set. A separate `wake` output is purely combinational. It works with the clock stopped and covers the enabled low-level sources and the unmasked pins whose raw value differs from the last sampled value.

Register map: address 0 holds the sense modes, address 1 the enables, address 2 the flags, and addresses 4, 5 and 6 the masks of groups 0, 1 and 2. Reads are combinational, and unused addresses read 0.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset all registers read 0, `irq` is 0 and, with the inputs idle high, `wake` is 0.
- R2: Sense code 2'b10 (address 0 bits [1:0] for A, bits [3:2] for B) sets the source flag on a 1-to-0 transition only. A 0-to-1 transition sets nothing.
- R3: Sense code 2'b11 sets the source flag on a 0-to-1 transition only.
- R4: Sense code 2'b01 sets the source flag on a transition in either direction.
- R5: Sense code 2'b00 sets the source flag on every cycle the synchronized input is low. A clear written while the input is still low leaves the flag at 1, because a set beats a clear in the same cycle. Once the input is high, a clear leaves the flag at 0.
- R6: Flag bit 2 records toggles on pins 7..0 under the address 4 mask. Flag bit 3 records toggles on pins 14..8 under the address 5 mask, where mask bit k selects pin 8+k and bit 7 reads 0. Flag bit 4 records toggles on pins 23..16 under the address 6 mask. Pin 15 belongs to no group.
- R7: A toggle on a pin whose mask bit is 0 sets no flag.
- R8: Writing address 2 clears each flag whose written bit is 1 and leaves flags written with 0 unchanged. Flags fall only through such a write. Bits 0 and 1 are sources A and B.
- R9: `irq` is 1 exactly when some flag is 1 and its address 1 enable bit (same bit position as the flag) is 1.
- R10: `wake` is asserted with no clock running in two cases. The first is a source that is enabled, in sense code 00 and whose raw input is low. The second is an unmasked pin in an enabled group whose raw value differs from its last sampled value.
- R11: Writing sense modes or masks while the inputs are steady sets no flag.
- R12: A flag and `irq` first show an input change after the third rising clock edge that follows the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_in | input | 2 | Dedicated request inputs, bit 0 = source A |
| pin_in | input | 24 | General pins |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| irq | output | 1 | Combined interrupt request |
| wake | output | 1 | Asynchronous wake request |

## Verification
A synchronizer or previous-value register that holds the wrong value shows up as a flag that is set one edge early or late, or as a spurious flag right after a configuration write. The bench therefore samples the flags both after the second and after the third edge following an input change. A wrong sense decode or mask bit position sets the wrong flag bit, or no bit, within three cycles, and the flag register readback shows it. A wrong set-versus-clear priority shows in the very next read after a clear is written while a low level is still present.

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl #(
  parameter int NEXT  = 2,
  parameter int NPIN  = 24,
  parameter int AW    = 3,
  parameter int DW    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEXT-1:0] ext_in,
  input  logic [NPIN-1:0] pin_in,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            irq,
  output logic            wake
);
  localparam int NFLAG = NEXT + 3;
  localparam logic [AW-1:0] A_SENSE = 3'd0, A_EN = 3'd1, A_FLAG = 3'd2,
                            A_MASK0 = 3'd4, A_MASK1 = 3'd5, A_MASK2 = 3'd6;

  logic [NEXT-1:0]   e_s1, e_s2, e_prev;
  logic [NPIN-1:0]   p_s1, p_s2, p_prev;
  logic [2*NEXT-1:0] sense;
  logic [NFLAG-1:0]  enable, flags, set, clr;
  logic [7:0]        mask0, mask2;
  logic [6:0]        mask1;

  wire [NPIN-1:0] mask_all = {mask2, 1'b0, mask1, mask0};
  wire [NPIN-1:0] pc_hit   = (p_s2 ^ p_prev) & mask_all;
  wire [NPIN-1:0] pc_raw   = (pin_in ^ p_prev) & mask_all;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      e_s1 <= '1; e_s2 <= '1; e_prev <= '1;
      p_s1 <= '1; p_s2 <= '1; p_prev <= '1;
    end else begin
      e_s1 <= ext_in; e_s2 <= e_s1; e_prev <= e_s2;
      p_s1 <= pin_in; p_s2 <= p_s1; p_prev <= p_s2;
    end

  logic [NEXT-1:0] lvl_wake;
  for (genvar i = 0; i < NEXT; i++) begin : g_src
    wire [1:0] m = sense[2*i +: 2];
    always_comb
      case (m)
        2'b00:   set[i] = ~e_s2[i];
        2'b01:   set[i] = e_s2[i] ^ e_prev[i];
        2'b10:   set[i] = e_prev[i] & ~e_s2[i];
        default: set[i] = ~e_prev[i] & e_s2[i];
      endcase
    assign lvl_wake[i] = enable[i] && (m == 2'b00) && !ext_in[i];
  end

  assign set[NEXT]   = |pc_hit[7:0];
  assign set[NEXT+1] = |pc_hit[14:8];
  assign set[NEXT+2] = |pc_hit[23:16];

  assign clr = (wr_en && addr == A_FLAG) ? wdata[NFLAG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sense <= '0; enable <= '0; flags <= '0;
      mask0 <= '0; mask1 <= '0; mask2 <= '0;
    end else begin
      flags <= (flags & ~clr) | set;
      if (wr_en)
        case (addr)
          A_SENSE: sense  <= wdata[2*NEXT-1:0];
          A_EN:    enable <= wdata[NFLAG-1:0];
          A_MASK0: mask0  <= wdata;
          A_MASK1: mask1  <= wdata[6:0];
          A_MASK2: mask2  <= wdata;
          default: ;
        endcase
    end

  always_comb
    case (addr)
      A_SENSE: rdata = DW'(sense);
      A_EN:    rdata = DW'(enable);
      A_FLAG:  rdata = DW'(flags);
      A_MASK0: rdata = mask0;
      A_MASK1: rdata = {1'b0, mask1};
      A_MASK2: rdata = mask2;
      default: rdata = '0;
    endcase

  assign irq  = |(flags & enable);
  assign wake = (|lvl_wake)
              | (enable[NEXT]   & |pc_raw[7:0])
              | (enable[NEXT+1] & |pc_raw[14:8])
              | (enable[NEXT+2] & |pc_raw[23:16]);
endmodule

module pin_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic [1:0] ext_in,
  input logic [1:0] e_s2,
  input logic [3:0] sense,
  input logic [4:0] enable,
  input logic [4:0] flags,
  input logic [7:0] mask0,
  input logic       irq,
  input logic       wake
);
  assert_flag_fall_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((~flags & $past(flags)) & ~(($past(wr_en) && $past(addr) == 3'd2) ? $past(wdata[4:0]) : 5'd0)) == 5'd0);

  assert_level_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sense[1:0] == 2'b00 && !e_s2[0]) |=> flags[0]);

  assert_level_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable[0] && sense[1:0] == 2'b00 && !ext_in[0]) |-> wake);

  assert_masked_group_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask0) == 8'd0 && !$past(flags[2])) |-> !flags[2]);

  assert_irq_needs_enabled_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((flags & enable) != 5'd0));
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .ext_in(ext_in), .e_s2(e_s2), .sense(sense), .enable(enable),
  .flags(flags), .mask0(mask0), .irq(irq), .wake(wake)
);

// File: tb/tb_pin_irq_ctrl.sv
module tb_pin_irq_ctrl;
  logic        clk = 1'b0, clk_run = 1'b1, rst_n = 1'b0;
  logic [1:0]  ext_in = 2'b11;
  logic [23:0] pin_in = '1;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq, wake;
  int errors = 0, checks = 0;

  pin_irq_ctrl dut (.clk(clk), .rst_n(rst_n), .ext_in(ext_in), .pin_in(pin_in),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .wake(wake));

  initial forever begin #4; if (clk_run) clk = ~clk; end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [2:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic rreg(logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic flags_is(string req, int exp);
    logic [7:0] d;
    rreg(3'd2, d); check(req, d, exp);
  endtask

  task automatic settle_clear();
    tick(4); wreg(3'd2, 8'h1f);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 8; a++) begin
      rreg(3'(a), d); check("R1 reg", d, 0);
    end
    check("R1 irq", irq, 0);
    check("R1 wake", wake, 0);
  endtask

  task automatic t_falling();
    wreg(3'd0, 8'b0000_0010); wreg(3'd1, 8'h01);
    ext_in[0] = 1'b0;
    tick(2); flags_is("R12 not yet", 0); check("R12 irq not yet", irq, 0);
    tick(1); flags_is("R2/R12 falling", 1); check("R9 irq", irq, 1);
    wreg(3'd2, 8'h01); flags_is("R8 clear", 0);
    ext_in[0] = 1'b1; tick(4);
    flags_is("R2 rise ignored", 0);
  endtask

  task automatic t_rising();
    wreg(3'd0, 8'b0000_1110);
    ext_in[1] = 1'b0; tick(4);
    flags_is("R3 fall ignored", 0);
    ext_in[1] = 1'b1; tick(4);
    flags_is("R3 rising", 2);
    settle_clear();
  endtask

  task automatic t_anychange();
    wreg(3'd0, 8'b0000_0001);
    ext_in[0] = 1'b0; tick(4); flags_is("R4 fall", 1);
    wreg(3'd2, 8'h01);
    ext_in[0] = 1'b1; tick(4); flags_is("R4 rise", 1);
    settle_clear();
  endtask

  task automatic t_level();
    wreg(3'd0, 8'b0000_0000);
    ext_in[0] = 1'b0; tick(3); flags_is("R5 level", 1);
    wreg(3'd2, 8'h01); flags_is("R5 refire", 1);
    tick(3); flags_is("R5 held", 1);
    ext_in[0] = 1'b1; tick(4);
    wreg(3'd2, 8'h01); tick(2); flags_is("R5 released", 0);
  endtask

  task automatic t_groups();
    wreg(3'd1, 8'h1c);
    wreg(3'd4, 8'h08); wreg(3'd5, 8'h81); wreg(3'd6, 8'h80);
    begin logic [7:0] d; rreg(3'd5, d); check("R6 mask1 bit7 reads 0", d, 8'h01); end
    pin_in[4] = 1'b0; tick(4); flags_is("R7 unmasked pin", 0);
    pin_in[3] = 1'b0; tick(4); flags_is("R6 group0", 5'h04);
    check("R9 group irq", irq, 1);
    pin_in[8] = 1'b0; tick(4); flags_is("R6 group1", 5'h0c);
    pin_in[23] = 1'b0; tick(4); flags_is("R6 group2", 5'h1c);
    wreg(3'd2, 8'h08); flags_is("R8 partial clear", 5'h14);
    wreg(3'd2, 8'h00); flags_is("R8 zero write", 5'h14);
    wreg(3'd2, 8'h1f);
    wreg(3'd4, 8'hff); wreg(3'd5, 8'hff); wreg(3'd6, 8'hff);
    flags_is("R11 mask write", 0);
    pin_in[15] = 1'b0; tick(4); flags_is("R6 pin15 ungrouped", 0);
    pin_in[3] = 1'b1; tick(4); flags_is("R6 group0 rise", 5'h04);
    wreg(3'd1, 8'h00); check("R9 irq off when disabled", irq, 0);
    pin_in = '1; settle_clear();
    wreg(3'd4, 8'h00); wreg(3'd5, 8'h00); wreg(3'd6, 8'h00);
  endtask

  task automatic t_config();
    wreg(3'd0, 8'h0f); wreg(3'd0, 8'h0a); wreg(3'd0, 8'h05); wreg(3'd0, 8'h00);
    tick(2); flags_is("R11 sense writes", 0);
  endtask

  task automatic t_wake();
    wreg(3'd0, 8'h00); wreg(3'd1, 8'h05); wreg(3'd4, 8'h01);
    check("R10 idle", wake, 0);
    clk_run = 1'b0; #20;
    pin_in[0] = 1'b0; #1; check("R10 pin wake", wake, 1);
    pin_in[0] = 1'b1; #1; check("R10 pin back", wake, 0);
    ext_in[0] = 1'b0; #1; check("R10 level wake", wake, 1);
    ext_in[0] = 1'b1; #1; check("R10 level back", wake, 0);
    ext_in[1] = 1'b0; #1; check("R10 disabled source", wake, 0);
    ext_in[1] = 1'b1; #1;
    clk_run = 1'b1; tick(2);
    wreg(3'd4, 8'h00); settle_clear();
  endtask

  initial begin
    #3000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1'b1; tick(2);
    t_reset();
    t_falling();
    t_rising();
    t_anychange();
    t_level();
    t_groups();
    t_config();
    t_wake();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule